// File: doc/BRIEF.md
# End-of-Charge Battery Presence Detector

This sequencer sits beside a charger controller. It watches for the end of a constant-voltage charge and then checks whether a battery is still attached to the charge node. When termination is enabled, it needs two conditions together: the cell is close to the regulation target, and the charge current has fallen to the termination level. At that point it ends charging and reports "done" on the status field. It then switches on a small test discharge sink for a fixed number of clock cycles. On the last cycle of that window it reads a comparator that says whether the battery node is still above the regulation level minus the recharge margin. If the node held up, a battery is there: the fault field reads clear and the block stays in the done state. If the node sagged, no battery is there: the fault field reads "no battery", the register file gets a one-cycle load-defaults strobe, and after a fixed hold time a one-cycle restart request sends the charger back into charging.

The block has four named states. CHARGE is the reset state: charging is in progress or the block is waiting to terminate. PROBE means the sink is on and the detection window is running. PRESENT means charging has ended and a battery was found. ABSENT means no battery was found and the restart hold is running. The transitions are: terminate (CHARGE to PROBE), abort (PROBE to CHARGE when termination is disabled), verdict-present (PROBE to PRESENT), verdict-absent (PROBE to ABSENT), release (PRESENT to CHARGE when termination is disabled) and restart (ABSENT to CHARGE when the hold expires). All outputs are registered and change on the same edge as the state.

Status codes used on `stat_o`: 2'b01 = charging, 2'b10 = charge done. Fault codes used on `fault_o`: 3'b000 = no fault, 3'b111 = battery absent.

Top module: `eoc_presence_seq`

## Requirements
- R1: After reset, `stat_o` is 2'b01, `fault_o` is 3'b000, and `sink_en_o`, `load_defaults_o` and `restart_req_o` are all low.
- R2: While `term_en_i` is low, the block never terminates, whatever `near_reg_i` and `term_cur_i` do. `stat_o` stays 2'b01 and `sink_en_o` stays low.
- R3: In CHARGE, the edge at which `term_en_i`, `near_reg_i` and `term_cur_i` are all high is followed by `stat_o` = 2'b10 and `sink_en_o` high.
- R4: Unless the sequence is aborted, `sink_en_o` stays high for exactly DETECT_CYCLES consecutive cycles and then drops.
- R5: `above_rch_i` is used only at the edge that closes the last sink cycle. Its value during earlier sink cycles has no effect on the verdict.
- R6: A present verdict gives `fault_o` = 3'b000 and `stat_o` = 2'b10. The block holds this until `term_en_i` goes low, and then returns to `stat_o` = 2'b01.
- R7: An absent verdict gives `fault_o` = 3'b111 and a `load_defaults_o` pulse exactly one cycle long, in the first cycle after the sink turns off.
- R8: After an absent verdict, `restart_req_o` pulses for exactly one cycle, RESTART_CYCLES cycles after the `load_defaults_o` pulse. In that same cycle `stat_o` returns to 2'b01. `fault_o` keeps 3'b111 until the next present verdict.
- R9: If `term_en_i` is low at an edge during PROBE, the sink turns off at that edge and `stat_o` returns to 2'b01. No strobe is issued and `fault_o` does not change.
- R10: Once an absent verdict has been given, clearing `term_en_i` does not cancel the restart hold or the restart request.
- R11: `load_defaults_o` and `restart_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_en_i | input | 1 | Termination (and presence check) enable |
| near_reg_i | input | 1 | Battery node is close to the regulation voltage |
| term_cur_i | input | 1 | Charge current is at or below the termination level |
| above_rch_i | input | 1 | Battery node is above regulation minus recharge margin |
| sink_en_o | output | 1 | Turns on the test discharge sink |
| stat_o | output | 2 | Status field (01 charging, 10 done) |
| fault_o | output | 3 | Fault field (000 none, 111 no battery) |
| load_defaults_o | output | 1 | One-cycle strobe telling the register file to load defaults |
| restart_req_o | output | 1 | One-cycle request to start charging again |

## Verification
A wrong state shows at the ports within one cycle, because every output is a registered decode of the next state. Examples: a sink that lights without a termination condition, a status field that stays at "done" after an abort, or a strobe that lasts two cycles. A wrong window length shows only at the window boundary. So the bench counts sink-high cycles exactly, and it places the deciding comparator level on the last sink cycle only, with the opposite level before it. A wrong sampling point then flips the verdict, which is visible one cycle later on the fault field and on the load-defaults strobe. A fault in the restart hold shows as an early or late restart pulse, so its cycle is checked exactly. It is also checked with termination disabled in the middle of the hold.

// File: rtl/eoc_pkg.sv
package eoc_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE  = 2'd0,
        ST_PROBE   = 2'd1,
        ST_PRESENT = 2'd2,
        ST_ABSENT  = 2'd3
    } eoc_state_e;

    localparam logic [1:0] STAT_CHARGING = 2'b01;
    localparam logic [1:0] STAT_DONE     = 2'b10;

    localparam logic [2:0] FLT_NONE      = 3'b000;
    localparam logic [2:0] FLT_NO_BATT   = 3'b111;

endpackage

// File: rtl/eoc_countdown.sv
module eoc_countdown #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);
    localparam int unsigned W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIMIT_W = W'(LIMIT);
    localparam logic [W-1:0] ONE_W   = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LIMIT_W;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE_W;
        end
    end

    assign last_o = run_i && (cnt_q == ONE_W);

    // R4: the count never exceeds the programmed window length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT_W);

    // R4: a load always starts a full-length window
    p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == LIMIT_W));

endmodule

// File: rtl/eoc_status_out.sv
module eoc_status_out
    import eoc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  eoc_state_e next_state_i,
    input  logic       go_present_i,
    input  logic       go_absent_i,
    input  logic       go_restart_i,
    output logic       sink_en_o,
    output logic [1:0] stat_o,
    output logic [2:0] fault_o,
    output logic       load_defaults_o,
    output logic       restart_req_o
);
    logic [1:0] stat_d;
    logic       sink_d;

    always_comb begin
        unique case (next_state_i)
            ST_CHARGE: begin
                stat_d = STAT_CHARGING;
                sink_d = 1'b0;
            end
            ST_PROBE: begin
                stat_d = STAT_DONE;
                sink_d = 1'b1;
            end
            ST_PRESENT: begin
                stat_d = STAT_DONE;
                sink_d = 1'b0;
            end
            ST_ABSENT: begin
                stat_d = STAT_DONE;
                sink_d = 1'b0;
            end
            default: begin
                stat_d = STAT_CHARGING;
                sink_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o          <= STAT_CHARGING;
            sink_en_o       <= 1'b0;
            fault_o         <= FLT_NONE;
            load_defaults_o <= 1'b0;
            restart_req_o   <= 1'b0;
        end else begin
            stat_o          <= stat_d;
            sink_en_o       <= sink_d;
            load_defaults_o <= go_absent_i;
            restart_req_o   <= go_restart_i;
            if (go_absent_i) begin
                fault_o <= FLT_NO_BATT;
            end else if (go_present_i) begin
                fault_o <= FLT_NONE;
            end
        end
    end

    // R7: the load-defaults strobe lasts a single cycle
    p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults_o |=> !load_defaults_o);

    // R8: the restart request lasts a single cycle
    p_restart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |=> !restart_req_o);

    // R11: the two strobes never coincide
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_defaults_o && restart_req_o));

    // R7: the defaults strobe comes with the no-battery fault
    p_absent_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults_o |-> (fault_o == FLT_NO_BATT));

endmodule

// File: rtl/eoc_presence_seq.sv
module eoc_presence_seq
    import eoc_pkg::*;
#(
    parameter int unsigned DETECT_CYCLES  = 256,
    parameter int unsigned RESTART_CYCLES = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       term_en_i,
    input  logic       near_reg_i,
    input  logic       term_cur_i,
    input  logic       above_rch_i,
    output logic       sink_en_o,
    output logic [1:0] stat_o,
    output logic [2:0] fault_o,
    output logic       load_defaults_o,
    output logic       restart_req_o
);
    eoc_state_e state_q;
    eoc_state_e state_d;

    logic probe_last;
    logic hold_last;
    logic go_probe;
    logic go_abort;
    logic go_present;
    logic go_absent;
    logic go_release;
    logic go_restart;

    // transition decode
    always_comb begin
        go_probe   = (state_q == ST_CHARGE)  && term_en_i && near_reg_i && term_cur_i;
        go_abort   = (state_q == ST_PROBE)   && !term_en_i;
        go_present = (state_q == ST_PROBE)   && term_en_i && probe_last && above_rch_i;
        go_absent  = (state_q == ST_PROBE)   && term_en_i && probe_last && !above_rch_i;
        go_release = (state_q == ST_PRESENT) && !term_en_i;
        go_restart = (state_q == ST_ABSENT)  && hold_last;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHARGE: begin
                if (go_probe) state_d = ST_PROBE;
            end
            ST_PROBE: begin
                if (go_abort)        state_d = ST_CHARGE;
                else if (go_present) state_d = ST_PRESENT;
                else if (go_absent)  state_d = ST_ABSENT;
            end
            ST_PRESENT: begin
                if (go_release) state_d = ST_CHARGE;
            end
            ST_ABSENT: begin
                if (go_restart) state_d = ST_CHARGE;
            end
            default: state_d = ST_CHARGE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CHARGE;
        else        state_q <= state_d;
    end

    eoc_countdown #(.LIMIT(DETECT_CYCLES)) i_detect_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (go_probe),
        .run_i  (state_q == ST_PROBE),
        .last_o (probe_last)
    );

    eoc_countdown #(.LIMIT(RESTART_CYCLES)) i_restart_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (go_absent),
        .run_i  (state_q == ST_ABSENT),
        .last_o (hold_last)
    );

    eoc_status_out i_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .next_state_i    (state_d),
        .go_present_i    (go_present),
        .go_absent_i     (go_absent),
        .go_restart_i    (go_restart),
        .sink_en_o       (sink_en_o),
        .stat_o          (stat_o),
        .fault_o         (fault_o),
        .load_defaults_o (load_defaults_o),
        .restart_req_o   (restart_req_o)
    );

    // R2: no termination while the enable is low
    p_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHARGE) && !term_en_i) |=> !sink_en_o);

    // R3: the sink only starts after a full termination condition
    p_sink_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_en_o) |-> $past(term_en_i && near_reg_i && term_cur_i));

    // R9: dropping the enable during the window kills the sink
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_en_o && !term_en_i) |=> (!sink_en_o && !load_defaults_o));

    // R8: a restart request only follows the absent hold
    p_restart_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req_o |-> ($past(state_q) == ST_ABSENT));

    // R10: the absent hold is left only through the restart transition
    p_hold_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ABSENT) && !hold_last) |=> (state_q == ST_ABSENT));

endmodule

// File: tb/test_eoc_presence_seq.sv
module test_eoc_presence_seq;

    localparam int unsigned DET = 6;
    localparam int unsigned RST_HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       term_en = 1'b0;
    logic       near_reg = 1'b0;
    logic       term_cur = 1'b0;
    logic       above_rch = 1'b0;
    logic       sink_en;
    logic [1:0] stat;
    logic [2:0] fault;
    logic       load_def;
    logic       restart;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    eoc_presence_seq #(
        .DETECT_CYCLES  (DET),
        .RESTART_CYCLES (RST_HOLD)
    ) i_eoc_presence_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .term_en_i       (term_en),
        .near_reg_i      (near_reg),
        .term_cur_i      (term_cur),
        .above_rch_i     (above_rch),
        .sink_en_o       (sink_en),
        .stat_o          (stat),
        .fault_o         (fault),
        .load_defaults_o (load_def),
        .restart_req_o   (restart)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "stat", stat, 1);
        chk("R1", "fault", fault, 0);
        chk("R1", "sink", sink_en, 0);
        chk("R1", "load_defaults", load_def, 0);
        chk("R1", "restart", restart, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_gated();
        term_en = 1'b0;
        near_reg = 1'b1;
        term_cur = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R2", "sink", sink_en, 0);
            chk("R2", "stat", stat, 1);
        end
        near_reg = 1'b0;
        term_cur = 1'b0;
        @(negedge clk);
    endtask

    // Start a termination. On return the first sink cycle has been sampled.
    task automatic trigger();
        term_en = 1'b1;
        near_reg = 1'b1;
        term_cur = 1'b1;
        @(negedge clk);
        near_reg = 1'b0;
        term_cur = 1'b0;
        chk("R3", "sink on", sink_en, 1);
        chk("R3", "stat done", stat, 2);
    endtask

    // Hold the comparator opposite to the verdict until the last sink cycle.
    task automatic run_probe(input bit verdict);
        above_rch = ~verdict;
        for (int i = 2; i <= DET; i++) begin
            @(negedge clk);
            chk("R4", "sink during window", sink_en, 1);
        end
        above_rch = verdict;
        @(negedge clk);
        above_rch = ~verdict;
        chk("R4", "sink off after window", sink_en, 0);
    endtask

    task automatic t_absent();
        trigger();
        run_probe(1'b0);
        chk("R5", "late-low verdict gives no-battery fault", fault, 7);
        chk("R7", "load_defaults first cycle", load_def, 1);
        chk("R11", "restart not with load", restart, 0);
        chk("R7", "stat during hold", stat, 2);
        term_en = 1'b0;
        @(negedge clk);
        chk("R7", "load_defaults one cycle", load_def, 0);
        for (int i = 2; i < RST_HOLD; i++) begin
            @(negedge clk);
            chk("R10", "hold kept without enable", stat, 2);
            chk("R8", "no early restart", restart, 0);
        end
        @(negedge clk);
        chk("R8", "restart pulse", restart, 1);
        chk("R8", "stat charging", stat, 1);
        chk("R8", "fault kept", fault, 7);
        chk("R11", "load not with restart", load_def, 0);
        @(negedge clk);
        chk("R8", "restart one cycle", restart, 0);
        chk("R8", "fault still kept", fault, 7);
    endtask

    task automatic t_present();
        trigger();
        run_probe(1'b1);
        chk("R5", "late-high verdict gives present", fault, 0);
        chk("R6", "stat done", stat, 2);
        chk("R6", "no load strobe", load_def, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R6", "held done", stat, 2);
            chk("R6", "no restart", restart, 0);
        end
        term_en = 1'b0;
        @(negedge clk);
        chk("R6", "release to charging", stat, 1);
    endtask

    task automatic t_abort();
        trigger();
        @(negedge clk);
        term_en = 1'b0;
        @(negedge clk);
        chk("R9", "sink off", sink_en, 0);
        chk("R9", "stat charging", stat, 1);
        chk("R9", "fault unchanged", fault, 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R9", "no load strobe", load_def, 0);
            chk("R9", "no restart", restart, 0);
        end
    endtask

    initial begin
        t_reset();
        t_gated();
        t_absent();
        term_en = 1'b1;
        repeat (2) @(negedge clk);
        t_present();
        t_abort();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule